// File: doc/BRIEF.md
# Core Special I/O Register Unit

This block holds the handful of processor-owned registers that sit at the top of the I/O window of an 8-bit microcontroller, and it decodes every port access and data-space access that the core issues. A request names either an I/O port (short form, only the low six address bits count) or a data-space address (long form). Data-space addresses are split into three windows. The lowest window is the general register file, which is held inside this block. The middle window is the I/O space, shifted down by the register count. Everything above that is external memory.

Inside the I/O space, the eight highest ports are served locally, with no wait. They hold four address-page extensions, an indirect-jump extension, the two bytes of the stack pointer and a status byte, which this block only stores. Every other I/O port, and all external memory, is passed through to a byte-wide memory bus with a valid/ready handshake. That bus has no buffering, so a forwarded request is stalled exactly as long as the bus holds off ready. Local reads return data combinationally in the cycle of the request. Writes commit at the clock edge on which the request is accepted.

Top module: `core_sfr_unit`

## Requirements
- R1: After reset, all page extensions, the jump extension, the stack pointer and the status byte read 0, and their outputs are 0.
- R2: A port access to ports 0x38 to 0x3F (page data = 0x38, page X = 0x39, page Y = 0x3A, page Z = 0x3B, jump extension = 0x3C, SP low = 0x3D, SP high = 0x3E, status = 0x3F) is served locally. It never raises `mbus_valid`, `req_ready` is 1, and a read returns the register in the same cycle.
- R3: Each page register and the jump extension drives its 8-bit value on bits 23:16 of its 24-bit output, with bits 15:0 at 0. A read returns the 8-bit value.
- R4: A write to page register n (data = bit 0, X = bit 1, Y = bit 2, Z = bit 3) lands only when bit n of `PAGE_FEAT` is set. Otherwise the register keeps its value. The jump extension is always writable.
- R5: A write to SP low replaces SP bits 7:0 and keeps bits 15:8.
- R6: With `SP_WIDE`=1, a write to SP high replaces SP bits 15:8. With `SP_WIDE`=0, it is ignored. A read of SP high returns SP bits 15:8, which is always 0 with `SP_WIDE`=0.
- R7: The status byte stores all 8 written bits unchanged, drives them on `sreg_o`, and returns them on a read.
- R8: Only `req_wdata[7:0]` is used. Bits 15:8 have no effect on any register or on the bus.
- R9: Data-space decode. An address below 32 selects general register (address). An address from 32 to 95 selects I/O port (address − 32), with the same local/forwarded split as a port access. An address of 96 or more is forwarded with `mbus_addr` = `DATA_BASE` + address.
- R10: A port access, or its data-space alias, to ports 0x00 to 0x37 is forwarded with `mbus_addr` = `DATA_BASE` + 32 + port. `mbus_write` equals `req_write`, and `mbus_wdata` is the low write byte. `req_ready` follows `mbus_ready`, and `rsp_rdata` follows `mbus_rdata`.
- R11: A local write commits at the clock edge where `req_valid` is high. During that cycle `rsp_rdata` shows the value held before the write, and the new value is visible from the next cycle.
- R12: The 32 general registers hold 8 bits each. They are written and read through data addresses 0 to 31, without any bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_is_data | input | 1 | 1 = data-space address, 0 = I/O port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Port number or data-space address |
| req_wdata | input | 16 | Write data, low byte used |
| rsp_rdata | output | 8 | Read data, same cycle |
| mbus_valid | output | 1 | Forwarded access present |
| mbus_ready | input | 1 | Memory bus accepts |
| mbus_write | output | 1 | Forwarded access is a write |
| mbus_addr | output | 24 | Forwarded byte address |
| mbus_wdata | output | 8 | Forwarded write byte |
| mbus_rdata | input | 8 | Forwarded read byte |
| page_data_o | output | 24 | Data page extension, value in 23:16 |
| page_x_o | output | 24 | X page extension, value in 23:16 |
| page_y_o | output | 24 | Y page extension, value in 23:16 |
| page_z_o | output | 24 | Z page extension, value in 23:16 |
| jump_ext_o | output | 24 | Indirect-jump extension, value in 23:16 |
| sp_o | output | 16 | Stack pointer |
| sreg_o | output | 8 | Status byte |

## Verification
Two things can happen in the same cycle: a local register is written, and `rsp_rdata` reports that same register. The bench sweeps writes over all eight local ports through both access forms. During each write cycle it compares `rsp_rdata` with the value the model held before the write, and from the next cycle it compares reads against the updated model. A second overlap is a forwarded access stalled by `mbus_ready` low while local ports stay ready. The bench drops bus ready and checks that the forwarded request is held off and that a local access made during the stall is still served at once.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  // Target of a decoded request
  typedef enum logic [1:0] {
    TGT_GPR  = 2'd0,
    TGT_SFR  = 2'd1,
    TGT_IOFW = 2'd2,
    TGT_MEM  = 2'd3
  } tgt_e;

  // Local register index = port - (first local port); order fixed by port map
  localparam int unsigned SFR_NUM    = 8;
  localparam int unsigned SFR_IDX_W  = 3;
  localparam int unsigned PAGE_NUM   = 4;
  localparam logic [2:0]  SFR_JUMP   = 3'd4;
  localparam logic [2:0]  SFR_SPLO   = 3'd5;
  localparam logic [2:0]  SFR_SPHI   = 3'd6;
  localparam logic [2:0]  SFR_STAT   = 3'd7;

endpackage

// File: rtl/sfr_decode.sv
module sfr_decode
  import sfr_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 16,
  parameter int unsigned           NUM_GPR   = 32,
  parameter int unsigned           NUM_IO    = 64,
  parameter int unsigned           BUS_AW    = 24,
  parameter logic [BUS_AW-1:0]     DATA_BASE = 24'h010000,
  localparam int unsigned          GPR_AW    = $clog2(NUM_GPR),
  localparam int unsigned          PORT_W    = $clog2(NUM_IO)
) (
  input  logic                  is_data,
  input  logic [ADDR_W-1:0]     addr,
  output tgt_e                  tgt,
  output logic [GPR_AW-1:0]     gpr_idx,
  output logic [SFR_IDX_W-1:0]  sfr_idx,
  output logic [BUS_AW-1:0]     bus_addr
);

  localparam logic [ADDR_W-1:0] GPR_LIM = ADDR_W'(NUM_GPR);
  localparam logic [ADDR_W-1:0] IO_LIM  = ADDR_W'(NUM_GPR + NUM_IO);
  localparam logic [BUS_AW-1:0] IO_BASE = DATA_BASE + BUS_AW'(NUM_GPR);
  localparam logic [PORT_W-SFR_IDX_W-1:0] SFR_TOP = '1;

  logic [ADDR_W-1:0] io_off;
  logic [PORT_W-1:0] port;
  logic              in_io;
  logic              unused_off;

  assign io_off     = addr - GPR_LIM;
  assign unused_off = ^io_off[ADDR_W-1:PORT_W];

  always_comb begin
    in_io = 1'b0;
    port  = '0;
    if (!is_data) begin
      in_io = 1'b1;
      port  = addr[PORT_W-1:0];
    end else if (addr >= GPR_LIM && addr < IO_LIM) begin
      in_io = 1'b1;
      port  = io_off[PORT_W-1:0];
    end
  end

  always_comb begin
    gpr_idx  = addr[GPR_AW-1:0];
    sfr_idx  = port[SFR_IDX_W-1:0];
    bus_addr = DATA_BASE + BUS_AW'(addr);
    if (in_io) begin
      if (port[PORT_W-1:SFR_IDX_W] == SFR_TOP) begin
        tgt = TGT_SFR;
      end else begin
        tgt      = TGT_IOFW;
        bus_addr = IO_BASE + BUS_AW'(port);
      end
    end else if (addr < GPR_LIM) begin
      tgt = TGT_GPR;
    end else begin
      tgt = TGT_MEM;
    end
  end

endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];

  // R12
  gpr_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/sfr_bank.sv
module sfr_bank
  import sfr_pkg::*;
#(
  parameter logic [PAGE_NUM-1:0] PAGE_FEAT = '1,
  parameter bit                  SP_WIDE   = 1'b1,
  parameter int unsigned         EXT_W     = 24,
  localparam int unsigned        EXT_PAD   = EXT_W - 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SFR_IDX_W-1:0] idx,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [EXT_W-1:0]     page_ext [PAGE_NUM],
  output logic [EXT_W-1:0]     jump_ext,
  output logic [15:0]          sp,
  output logic [7:0]           stat
);

  logic [7:0] page_val [PAGE_NUM];

  // Page extension registers, each gated by its feature bit
  for (genvar g = 0; g < PAGE_NUM; g++) begin : g_page
    logic       en;
    logic [7:0] q, d;
    if (PAGE_FEAT[g]) begin : g_on
      assign en = we && (idx == SFR_IDX_W'(g));
    end else begin : g_off
      assign en = 1'b0;
      // R4
      page_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == SFR_IDX_W'(g)) |=> $stable(q));
    end
    always_comb d = en ? wdata : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign page_val[g] = q;
    assign page_ext[g] = {q, EXT_PAD'(0)};
  end

  // Jump extension, stack pointer bytes, status byte
  logic       jump_en, splo_en, sphi_en, stat_en;
  logic [7:0] jump_q, jump_d, splo_q, splo_d, sphi_q, sphi_d, stat_q, stat_d;

  assign jump_en = we && (idx == SFR_JUMP);
  assign splo_en = we && (idx == SFR_SPLO);
  assign stat_en = we && (idx == SFR_STAT);

  if (SP_WIDE) begin : g_sp16
    assign sphi_en = we && (idx == SFR_SPHI);
  end else begin : g_sp8
    assign sphi_en = 1'b0;
    // R6
    sp_hi_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == SFR_SPHI) |=> (sp[15:8] == 8'h00));
  end

  always_comb begin
    jump_d = jump_en ? wdata : jump_q;
    splo_d = splo_en ? wdata : splo_q;
    sphi_d = sphi_en ? wdata : sphi_q;
    stat_d = stat_en ? wdata : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jump_q <= '0;
      splo_q <= '0;
      sphi_q <= '0;
      stat_q <= '0;
    end else begin
      jump_q <= jump_d;
      splo_q <= splo_d;
      sphi_q <= sphi_d;
      stat_q <= stat_d;
    end
  end

  assign jump_ext = {jump_q, EXT_PAD'(0)};
  assign sp       = {sphi_q, splo_q};
  assign stat     = stat_q;

  always_comb begin
    case (idx)
      SFR_JUMP: rdata = jump_q;
      SFR_SPLO: rdata = splo_q;
      SFR_SPHI: rdata = sphi_q;
      SFR_STAT: rdata = stat_q;
      default:  rdata = page_val[idx[1:0]];
    endcase
  end

  // R5
  sp_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == SFR_SPLO) |=> (sp == {$past(sp[15:8]), $past(wdata)}));

  // R7
  stat_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == SFR_STAT) |=> (stat == $past(wdata)));

endmodule

// File: rtl/core_sfr_unit.sv
module core_sfr_unit
  import sfr_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       WDATA_W   = 16,
  parameter int unsigned       NUM_GPR   = 32,
  parameter int unsigned       NUM_IO    = 64,
  parameter int unsigned       BUS_AW    = 24,
  parameter logic [BUS_AW-1:0] DATA_BASE = 24'h010000,
  parameter logic [3:0]        PAGE_FEAT = 4'b1111,
  parameter bit                SP_WIDE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_data,
  input  logic              req_write,
  input  logic [15:0]       req_addr,
  input  logic [15:0]       req_wdata,
  output logic [7:0]        rsp_rdata,
  output logic              mbus_valid,
  input  logic              mbus_ready,
  output logic              mbus_write,
  output logic [23:0]       mbus_addr,
  output logic [7:0]        mbus_wdata,
  input  logic [7:0]        mbus_rdata,
  output logic [23:0]       page_data_o,
  output logic [23:0]       page_x_o,
  output logic [23:0]       page_y_o,
  output logic [23:0]       page_z_o,
  output logic [23:0]       jump_ext_o,
  output logic [15:0]       sp_o,
  output logic [7:0]        sreg_o
);

  localparam int unsigned GPR_AW = $clog2(NUM_GPR);
  localparam int unsigned PORT_W = $clog2(NUM_IO);
  localparam logic [ADDR_W-1:0] GPR_LIM = ADDR_W'(NUM_GPR);
  localparam logic [BUS_AW-1:0] IO_BASE = DATA_BASE + BUS_AW'(NUM_GPR);
  localparam logic [BUS_AW-1:0] IO_FW_END = IO_BASE + BUS_AW'(NUM_IO - SFR_NUM);

  tgt_e                 tgt;
  logic [GPR_AW-1:0]    gpr_idx;
  logic [SFR_IDX_W-1:0] sfr_idx;
  logic [BUS_AW-1:0]    bus_addr;
  logic                 fwd, fire;
  logic [7:0]           wbyte, gpr_rd, sfr_rd;
  logic [BUS_AW-1:0]    page_ext [PAGE_NUM];
  logic                 unused_wdata_hi;

  assign wbyte           = req_wdata[7:0];
  assign unused_wdata_hi = ^req_wdata[WDATA_W-1:8];

  sfr_decode #(
    .ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR), .NUM_IO(NUM_IO),
    .BUS_AW(BUS_AW), .DATA_BASE(DATA_BASE)
  ) u_dec (
    .is_data(req_is_data), .addr(req_addr), .tgt(tgt),
    .gpr_idx(gpr_idx), .sfr_idx(sfr_idx), .bus_addr(bus_addr)
  );

  assign fwd       = (tgt == TGT_IOFW) || (tgt == TGT_MEM);
  assign req_ready = fwd ? mbus_ready : 1'b1;
  assign fire      = req_valid && req_ready && req_write;

  gpr_file #(.DEPTH(NUM_GPR), .DW(8)) u_gpr (
    .clk(clk), .rst_n(rst_n), .we(fire && tgt == TGT_GPR),
    .addr(gpr_idx), .wdata(wbyte), .rdata(gpr_rd)
  );

  sfr_bank #(.PAGE_FEAT(PAGE_FEAT), .SP_WIDE(SP_WIDE), .EXT_W(BUS_AW)) u_sfr (
    .clk(clk), .rst_n(rst_n), .we(fire && tgt == TGT_SFR),
    .idx(sfr_idx), .wdata(wbyte), .rdata(sfr_rd),
    .page_ext(page_ext), .jump_ext(jump_ext_o), .sp(sp_o), .stat(sreg_o)
  );

  assign page_data_o = page_ext[0];
  assign page_x_o    = page_ext[1];
  assign page_y_o    = page_ext[2];
  assign page_z_o    = page_ext[3];

  assign mbus_valid = req_valid && fwd;
  assign mbus_write = req_write;
  assign mbus_addr  = bus_addr;
  assign mbus_wdata = wbyte;

  always_comb begin
    case (tgt)
      TGT_GPR: rsp_rdata = gpr_rd;
      TGT_SFR: rsp_rdata = sfr_rd;
      default: rsp_rdata = mbus_rdata;
    endcase
  end

  // R2
  local_port_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_data && req_addr[PORT_W-1:SFR_IDX_W] == '1)
      |-> (req_ready && !mbus_valid));

  // R12
  gpr_never_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_data && req_addr < GPR_LIM) |-> (!mbus_valid && req_ready));

  // R10
  io_fw_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mbus_valid && !req_is_data) |-> (mbus_addr >= IO_BASE && mbus_addr < IO_FW_END));

  // R11
  stat_write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_is_data && req_addr[PORT_W-1:0] == '1)
      |=> (sreg_o == $past(req_wdata[7:0])));

endmodule

// File: tb/core_sfr_unit_tb.sv
module core_sfr_unit_tb;

  localparam logic [3:0] FEAT0 = 4'b1011;
  localparam logic [3:0] FEAT1 = 4'b0100;
  localparam bit         SPW0  = 1'b1;
  localparam bit         SPW1  = 1'b0;
  localparam logic [23:0] DBASE = 24'h010000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_is_data = 0, req_write = 0, mbus_ready = 1;
  logic [15:0] req_addr = 0, req_wdata = 0;

  logic        rdy [2], bv [2], bw [2];
  logic [7:0]  rd [2], bwd [2], brd [2], sreg [2];
  logic [23:0] ba [2], pd [2], px [2], py [2], pz [2], je [2];
  logic [15:0] sp [2];

  assign brd[0] = ba[0][7:0] ^ 8'h5A;
  assign brd[1] = ba[1][7:0] ^ 8'h5A;

  core_sfr_unit #(.PAGE_FEAT(FEAT0), .SP_WIDE(SPW0), .DATA_BASE(DBASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_is_data(req_is_data), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rd[0]), .mbus_valid(bv[0]),
    .mbus_ready(mbus_ready), .mbus_write(bw[0]), .mbus_addr(ba[0]),
    .mbus_wdata(bwd[0]), .mbus_rdata(brd[0]), .page_data_o(pd[0]),
    .page_x_o(px[0]), .page_y_o(py[0]), .page_z_o(pz[0]),
    .jump_ext_o(je[0]), .sp_o(sp[0]), .sreg_o(sreg[0]));

  core_sfr_unit #(.PAGE_FEAT(FEAT1), .SP_WIDE(SPW1), .DATA_BASE(DBASE)) u_dut_sp8 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_is_data(req_is_data), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rd[1]), .mbus_valid(bv[1]),
    .mbus_ready(mbus_ready), .mbus_write(bw[1]), .mbus_addr(ba[1]),
    .mbus_wdata(bwd[1]), .mbus_rdata(brd[1]), .page_data_o(pd[1]),
    .page_x_o(px[1]), .page_y_o(py[1]), .page_z_o(pz[1]),
    .jump_ext_o(je[1]), .sp_o(sp[1]), .sreg_o(sreg[1]));

  int checks = 0, failures = 0;

  // Captured outputs during the request cycle
  logic        c_rdy [2], c_bv [2], c_bw [2];
  logic [7:0]  c_rd [2], c_bwd [2];
  logic [23:0] c_ba [2];

  // Reference model of the local registers
  logic [7:0]  m_page [2][4];
  logic [7:0]  m_jump [2], m_stat [2];
  logic [15:0] m_sp [2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic d, input logic w, input logic [15:0] a, input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1; req_is_data = d; req_write = w; req_addr = a; req_wdata = wd;
    #1;
    for (int k = 0; k < 2; k++) begin
      c_rdy[k] = rdy[k]; c_bv[k] = bv[k]; c_bw[k] = bw[k];
      c_rd[k] = rd[k]; c_bwd[k] = bwd[k]; c_ba[k] = ba[k];
    end
    @(posedge clk);
    #1 req_valid = 0; req_write = 0;
  endtask

  function automatic logic [7:0] exp_sfr(input int k, input int i);
    case (i)
      0, 1, 2, 3: return m_page[k][i];
      4: return m_jump[k];
      5: return m_sp[k][7:0];
      6: return m_sp[k][15:8];
      default: return m_stat[k];
    endcase
  endfunction

  task automatic m_write(input int k, input int i, input logic [7:0] v);
    logic [3:0] feat;
    bit spw;
    feat = (k == 0) ? FEAT0 : FEAT1;
    spw  = (k == 0) ? SPW0 : SPW1;
    if (i < 4) begin
      if (feat[i]) m_page[k][i] = v;
    end else if (i == 4) m_jump[k] = v;
    else if (i == 5) m_sp[k][7:0] = v;
    else if (i == 6) begin
      if (spw) m_sp[k][15:8] = v;
    end else m_stat[k] = v;
  endtask

  task automatic check_outputs(input string tag);
    for (int k = 0; k < 2; k++) begin
      chk(pd[k] == {m_page[k][0], 16'h0}, {tag, " R3 page data out"}, pd[k], {m_page[k][0], 16'h0});
      chk(px[k] == {m_page[k][1], 16'h0}, {tag, " R4 page x out"}, px[k], {m_page[k][1], 16'h0});
      chk(py[k] == {m_page[k][2], 16'h0}, {tag, " R4 page y out"}, py[k], {m_page[k][2], 16'h0});
      chk(pz[k] == {m_page[k][3], 16'h0}, {tag, " R4 page z out"}, pz[k], {m_page[k][3], 16'h0});
      chk(je[k] == {m_jump[k], 16'h0}, {tag, " R3 jump out"}, je[k], {m_jump[k], 16'h0});
      chk(sp[k] == m_sp[k], {tag, " R6 sp out"}, sp[k], m_sp[k]);
      chk(sreg[k] == m_stat[k], {tag, " R7 status out"}, sreg[k], m_stat[k]);
    end
  endtask

  task automatic read_all_local(input string tag);
    for (int i = 0; i < 8; i++) begin
      do_req(1'b0, 1'b0, 16'(8'h38 + i), 16'h0);
      for (int k = 0; k < 2; k++) begin
        chk(c_rd[k] == exp_sfr(k, i), {tag, " R2 local read"}, c_rd[k], exp_sfr(k, i));
        chk(c_rdy[k] && !c_bv[k], {tag, " R2 no bus"}, {c_rdy[k], c_bv[k]}, 2'b10);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, prior;
    logic [15:0] a;
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 4; i++) m_page[k][i] = 8'h00;
      m_jump[k] = 0; m_sp[k] = 0; m_stat[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check_outputs("R1 reset");
    read_all_local("R1 reset");

    // R12: general register sweep through data space
    for (int i = 0; i < 32; i++) do_req(1'b1, 1'b1, 16'(i), {8'hEE, 8'(i * 7 + 3)});
    for (int i = 0; i < 32; i++) begin
      do_req(1'b1, 1'b0, 16'(i), 16'h0);
      chk(c_rd[0] == 8'(i * 7 + 3), "R12 gpr read", c_rd[0], 8'(i * 7 + 3));
      chk(!c_bv[0] && c_rdy[0], "R12 gpr no bus", {c_bv[0], c_rdy[0]}, 2'b01);
    end

    // R2..R8, R11: local register write sweeps, three access forms
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 8; i++) begin
        v = 8'(i * 37 + r * 91 + 5);
        a = (r == 1) ? 16'(8'h58 + i) : (r == 2) ? 16'(16'hFF38 + i) : 16'(8'h38 + i);
        do_req(r == 1, 1'b1, a, {8'hC3 ^ 8'(r), v});
        for (int k = 0; k < 2; k++) begin
          prior = exp_sfr(k, i);
          chk(c_rd[k] == prior, "R11 prior value in write cycle", c_rd[k], prior);
          m_write(k, i, v);
        end
      end
      check_outputs("R4 R5 R6 R8 sweep");
      read_all_local("R9 R8 sweep");
    end

    // R5: SP low write keeps high byte
    do_req(1'b0, 1'b1, 16'h3E, 16'h00AB); m_write(0, 6, 8'hAB); m_write(1, 6, 8'hAB);
    do_req(1'b0, 1'b1, 16'h3D, 16'h7712); m_write(0, 5, 8'h12); m_write(1, 5, 8'h12);
    chk(sp[0] == 16'hAB12, "R5 sp low keeps high", sp[0], 16'hAB12);
    chk(sp[1] == 16'h0012, "R6 sp8 high ignored", sp[1], 16'h0012);
    do_req(1'b0, 1'b0, 16'h3E, 16'h0);
    chk(c_rd[1] == 8'h00, "R6 sp8 high reads zero", c_rd[1], 8'h00);
    chk(c_rd[0] == 8'hAB, "R6 sp16 high read", c_rd[0], 8'hAB);

    // R10: forwarded ports, both forms
    for (int p = 0; p < 56; p++) begin
      do_req(1'b0, p[0], 16'(p), {8'h99, 8'(p + 100)});
      chk(c_bv[0] && c_ba[0] == DBASE + 24'd32 + 24'(p), "R10 port fwd addr", c_ba[0], DBASE + 24'd32 + 24'(p));
      chk(c_bw[0] == p[0] && c_bwd[0] == 8'(p + 100), "R10 fwd write data", {c_bw[0], c_bwd[0]}, {p[0], 8'(p + 100)});
      chk(c_rd[0] == (8'(DBASE[7:0] + 8'd32 + 8'(p)) ^ 8'h5A), "R10 fwd read data", c_rd[0],
          8'(DBASE[7:0] + 8'd32 + 8'(p)) ^ 8'h5A);
      do_req(1'b1, 1'b0, 16'(32 + p), 16'h0);
      chk(c_bv[0] && c_ba[0] == DBASE + 24'd32 + 24'(p), "R9 data alias fwd", c_ba[0], DBASE + 24'd32 + 24'(p));
    end

    // R9: external memory window
    for (int j = 0; j < 6; j++) begin
      a = (j == 0) ? 16'h0060 : (j == 1) ? 16'h0061 : (j == 2) ? 16'h1234 :
          (j == 3) ? 16'h8000 : (j == 4) ? 16'hFFFE : 16'hFFFF;
      do_req(1'b1, 1'b1, a, 16'h0042);
      chk(c_bv[0] && c_ba[0] == DBASE + 24'(a), "R9 memory addr", c_ba[0], DBASE + 24'(a));
    end

    // R10: stall while bus not ready, local access still served
    mbus_ready = 1'b0;
    do_req(1'b0, 1'b1, 16'h0005, 16'h0001);
    chk(!c_rdy[0] && c_bv[0], "R10 stall holds ready low", {c_rdy[0], c_bv[0]}, 2'b01);
    do_req(1'b0, 1'b1, 16'h003F, 16'h00E7); m_write(0, 7, 8'hE7); m_write(1, 7, 8'hE7);
    chk(c_rdy[0] && !c_bv[0], "R2 local during stall", {c_rdy[0], c_bv[0]}, 2'b10);
    chk(sreg[0] == 8'hE7, "R7 status after stall write", sreg[0], 8'hE7);
    mbus_ready = 1'b1;
    check_outputs("R11 final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule